// File: doc/BRIEF.md
# Fractional timer clock prescaler

This block produces the advance stream for a core-local 64-bit system counter. Each cycle of the fabric clock, one of two source enables may mark an input cycle: the crystal reference enable, or an enable from an alternate source. The alternate source has already been brought into the clock domain, so it arrives as a synchronous enable. A 32-bit phase accumulator adds the programmed prescale value on every input cycle. Whenever the sum reaches 2^31, it emits a tick and takes 2^31 back off. The tick rate is therefore the input rate times prescale / 2^31. A value of 0x80000000 gives one tick per input cycle.

Each tick advances the system counter by a step of one or two. A control register selects the step and the source. A narrow write-only port programs the two registers. Software writes the prescale value once per configuration, and that write restarts the accumulator phase.

Top module: `tsp_top`

## Requirements
- R1: After reset, `count` is 0 and `tick` is 0. The control register is cleared, which selects the crystal enable and a step of 1. The prescale value is 0x80000000.
- R2: Take a prescale value P with P <= 0x80000000. After P is written, N input cycles yield exactly floor(N*P/2^31) cycles with `tick` high. For example, P = 0x40000000 gives one tick per two input cycles.
- R3: A prescale value of 0x80000000 or more gives a tick for every input cycle.
- R4: In a cycle with no input cycle, no tick follows and `count` holds its value.
- R5: Bit 8 of the control register selects the source. When it is 0, `xtal_en` marks input cycles. When it is 1, `alt_en` marks input cycles. The unselected enable has no effect.
- R6: Bit 9 of the control register selects the step. When it is 0, `count` advances by 1 per tick. When it is 1, `count` advances by 2 per tick. `count` changes on the same clock edge that raises `tick`.
- R7: A write to address 0x00 loads the control register. A write to address 0x08 loads the prescale register. Writes to any other address have no effect. A loaded value governs behaviour from the next cycle on.
- R8: A prescale write clears the accumulator. An input cycle that coincides with that write produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_en | input | 1 | Crystal reference input-cycle enable |
| alt_en | input | 1 | Alternate source input-cycle enable, already synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| tick | output | 1 | High for one cycle per counter advance |
| count | output | 64 | System counter value |

## Verification
The assertions assume the following about the inputs:
- The enables and the write strobe are sampled only at clock edges.
- The counter never gets near wrapping during a run.

The stimulus keeps within these limits:
- It changes inputs only on falling edges.
- It keeps runs to a few thousand ticks, far from 2^64.

Random prescale values are drawn at or below 0x80000000 wherever the closed-form tick count is checked. Larger values are used only in the saturation check, where every input cycle must tick.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int PS_W   = 32;
    localparam int CNT_W  = 64;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h00;
    localparam logic [ADDR_W-1:0] PS_ADDR   = 8'h08;
    localparam int SEL_BIT  = 8;
    localparam int STEP_BIT = 9;

    localparam logic [PS_W-1:0] UNITY = {1'b1, {(PS_W-1){1'b0}}};

    typedef struct packed {
        logic            src_alt;
        logic            step2;
        logic [PS_W-1:0] prescale;
    } cfg_t;

    typedef struct packed {
        logic [PS_W-1:0] acc;
        logic            tick;
    } phase_t;
endpackage

// File: rtl/tsp_regs.sv
module tsp_regs
    import tsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PS_W-1:0]   wr_data,
    output cfg_t              cfg,
    output logic              ps_wr
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        ps_wr = wr_en && (wr_addr == PS_ADDR);
        if (wr_en && (wr_addr == CTRL_ADDR)) begin
            cfg_d.src_alt = wr_data[SEL_BIT];
            cfg_d.step2   = wr_data[STEP_BIT];
        end
        if (ps_wr) begin
            cfg_d.prescale = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{src_alt: 1'b0, step2: 1'b0, prescale: UNITY};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R7: a write to another address leaves the configuration unchanged
    p_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_ADDR && wr_addr != PS_ADDR) |=> $stable(cfg_q));
endmodule

// File: rtl/tsp_phase.sv
module tsp_phase
    import tsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_en,
    input  logic            clear,
    input  logic [PS_W-1:0] prescale,
    output logic            tick_nx,
    output logic            tick
);
    phase_t ph_d, ph_q;
    logic [PS_W:0] sum;
    logic [PS_W:0] rem;

    always_comb begin
        ph_d      = ph_q;
        ph_d.tick = 1'b0;
        sum       = {1'b0, ph_q.acc} + {1'b0, prescale};
        rem       = sum - {1'b0, UNITY};
        if (clear) begin
            ph_d.acc = '0;
        end else if (src_en) begin
            if (sum >= {1'b0, UNITY}) begin
                ph_d.tick = 1'b1;
                if (rem >= {1'b0, UNITY}) begin
                    ph_d.acc = UNITY - 1'b1;
                end else begin
                    ph_d.acc = rem[PS_W-1:0];
                end
            end else begin
                ph_d.acc = sum[PS_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign tick_nx = ph_d.tick;
    assign tick    = ph_q.tick;

    // R2: residual phase always stays below one whole tick
    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.acc < UNITY);
    // R4: no input cycle, no tick
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_en && !clear) |=> !tick);
    // R3: unity or larger ratio ticks on every input cycle
    p_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_en && !clear && prescale >= UNITY) |=> tick);
    // R8: prescale write restarts phase and suppresses the tick
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!tick && ph_q.acc == '0));
endmodule

// File: rtl/tsp_count.sv
module tsp_count
    import tsp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             step2,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = cnt_q + (step2 ? CNT_W'(2) : CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/tsp_top.sv
module tsp_top
    import tsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_en,
    input  logic              alt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PS_W-1:0]   wr_data,
    output logic              tick,
    output logic [CNT_W-1:0]  count
);
    cfg_t cfg;
    logic ps_wr;
    logic src_en;
    logic tick_nx;

    tsp_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .ps_wr   (ps_wr)
    );

    assign src_en = cfg.src_alt ? alt_en : xtal_en;

    tsp_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_en   (src_en),
        .clear    (ps_wr),
        .prescale (cfg.prescale),
        .tick_nx  (tick_nx),
        .tick     (tick)
    );

    tsp_count u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick_nx),
        .step2 (cfg.step2),
        .count (count)
    );

    // R4: counter holds while no tick is raised
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> count == $past(count));
    // R6: each tick advances the counter by the configured step
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (count - $past(count)) == ($past(cfg.step2) ? 64'd2 : 64'd1));
    // R5: selected source absent means no tick next cycle
    p_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src_alt ? !alt_en : !xtal_en) |=> !tick);
endmodule

// File: tb/sim_tsp_top.sv
module sim_tsp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_en = 1'b0;
    logic        alt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tick;
    logic [63:0] count;

    int total = 0;
    int bad = 0;
    int ticks = 0;
    logic done = 1'b0;

    tsp_top u0 (.*);

    always #5 clk = ~clk;

    always @(negedge clk) if (tick) ticks++;

    function automatic longint exp_ticks(longint n, longint p);
        if (p >= 64'h8000_0000) return n;
        return (n * p) >> 31;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive xtal_en for n cycles; returns counter delta
    task automatic run_x(int n, output longint delta);
        longint c0;
        @(negedge clk);
        c0 = count; ticks = 0;
        for (int i = 0; i < n; i++) begin
            xtal_en = 1'b1;
            @(negedge clk);
        end
        xtal_en = 1'b0;
        @(negedge clk);
        delta = count - c0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint d;
        longint p;
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count, 0);
        chk("R1 tick", tick, 0);
        run_x(10, d);
        chk("R1 default 1:1 step1", d, 10);

        wr(8'h08, 32'h4000_0000);
        run_x(100, d);
        chk("R2 half rate delta", d, 50);
        chk("R2 half rate ticks", ticks, 50);

        wr(8'h08, 32'h8000_0000);
        run_x(37, d);
        chk("R3 unity", d, 37);
        wr(8'h08, 32'hFFFF_FFFF);
        run_x(20, d);
        chk("R3 above unity", d, 20);

        for (int k = 0; k < 5; k++) begin
            p = longint'($urandom_range(32'h7FFF_FFFF, 1));
            n = $urandom_range(300, 50);
            wr(8'h08, 32'(p));
            run_x(n, d);
            chk("R2 random ratio", ticks, exp_ticks(n, p));
        end

        begin
            longint c0;
            @(negedge clk); c0 = count; ticks = 0;
            repeat (20) @(negedge clk);
            chk("R4 idle hold", count - c0, 0);
            chk("R4 idle ticks", ticks, 0);
        end

        wr(8'h00, 32'h0000_0200);
        wr(8'h08, 32'h4000_0000);
        run_x(100, d);
        chk("R6 step2 delta", d, 100);
        chk("R6 step2 ticks", ticks, 50);

        // alternate source with noise on the crystal enable
        wr(8'h00, 32'h0000_0100);
        wr(8'h08, 32'h6000_0000);
        begin
            longint c0;
            int na = 0;
            @(negedge clk); c0 = count; ticks = 0;
            for (int i = 0; i < 200; i++) begin
                alt_en = 1'($urandom_range(1, 0));
                xtal_en = 1'($urandom_range(1, 0));
                if (alt_en) na++;
                @(negedge clk);
            end
            alt_en = 0; xtal_en = 0;
            @(negedge clk);
            chk("R5 alt source ticks", ticks, exp_ticks(na, 64'h6000_0000));
            chk("R5 alt source delta", count - c0, exp_ticks(na, 64'h6000_0000));
        end
        wr(8'h00, 32'h0);
        wr(8'h08, 32'h8000_0000);
        begin
            longint c0;
            @(negedge clk); c0 = count;
            repeat (15) begin alt_en = 1'b1; @(negedge clk); end
            alt_en = 1'b0; @(negedge clk);
            chk("R5 alt ignored when crystal selected", count - c0, 0);
        end

        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        run_x(10, d);
        chk("R7 unused addresses ignored", d, 10);

        // phase clear: one half-step then rewrite, next single cycle must not tick
        wr(8'h08, 32'h4000_0000);
        run_x(1, d);
        wr(8'h08, 32'h4000_0000);
        run_x(1, d);
        chk("R8 accumulator cleared", d, 0);
        run_x(1, d);
        chk("R8 tick after second half-step", d, 1);

        wr(8'h08, 32'h8000_0000);
        begin
            longint c0;
            @(negedge clk); c0 = count;
            xtal_en = 1'b1; wr_en = 1'b1; wr_addr = 8'h08; wr_data = 32'h8000_0000;
            @(negedge clk);
            wr_en = 1'b0; xtal_en = 1'b0;
            @(negedge clk);
            chk("R8 write cycle no tick", count - c0, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule